// File: doc/BRIEF.md
# Gated Two-Digit Decimal Reaction Timer

This block measures a short interval in hundredths of a second. A free-running 100 Hz timebase arrives as a one-cycle enable pulse on the system clock. While a counting gate is open, each pulse adds one to a two-digit decimal count, so every step is 0.01 s and the largest reading is 0.99 s. A start event opens the gate. A stop event closes it, and the elapsed time then stays on the outputs until the next start or a clear.

Each digit is a four-bit decade. It returns to zero when its next value would show the bit pattern of ten, and the wrap of the units decade advances the tens decade. A display register follows the live count while hold is high. It freezes the moment hold goes low, so a reading can be taken while counting goes on. When the count wraps from 99 to 00, a sticky flag records it. Every part of the block works on the single system clock. The inputs are taken to be clean and already synchronous.

Top module: `rxn_timer`

## Requirements
- R1: While clear is high at a clock edge, that edge sets both digits to 0, the display to 0, the running flag to 0 and the overflow flag to 0. Clear overrides every other input.
- R2: The units digit takes the values 0 to 9 in order, one step per counted tick. A counted tick at 9 returns it to 0.
- R3: The tens digit advances by one exactly on the counted tick that wraps the units digit from 9 to 0. From 9 it returns to 0.
- R4: A counted tick at count 99 gives count 00 and sets the overflow flag. The flag stays set until clear.
- R5: While the gate is closed (running flag low), ticks leave both digits unchanged.
- R6: Start without stop sets the running flag at that edge. A tick in the same cycle as start is not counted.
- R7: Stop clears the running flag at that edge, and a tick in the same cycle as stop is not counted. While the gate is closed, further stop pulses change nothing.
- R8: When start and stop are high in the same cycle, stop wins and the running flag is low after that edge.
- R9: At an edge with hold high, the display takes the count produced by that edge. At an edge with hold low, the display keeps its value.
- R10: Each digit and each display digit is always a value from 0 to 9 (binary 0000 to 1001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_i | input | 1 | Synchronous clear of count, gate, display and overflow |
| tick_i | input | 1 | One-cycle 100 Hz timebase enable |
| start_i | input | 1 | Opens the counting gate |
| stop_i | input | 1 | Closes the counting gate (priority over start) |
| hold_i | input | 1 | High: display follows the count; low: display frozen |
| units_o | output | 4 | Live units digit (0.01 s), BCD |
| tens_o | output | 4 | Live tens digit (0.1 s), BCD |
| disp_units_o | output | 4 | Held display units digit |
| disp_tens_o | output | 4 | Held display tens digit |
| running_o | output | 1 | Gate open |
| overflow_o | output | 1 | Sticky flag for a wrap from 99 to 00 |

## Verification
Several functions can meet in one cycle. A tick can coincide with stop, which must lose the tick, or with start, which must not count it. Start can coincide with stop, which must leave the gate closed, and clear can coincide with a tick and a start, which must leave everything at zero. The bench drives each of these pairs in one cycle and compares the digits, flags and display after that edge against a behavioural integer model. The same comparison is made at the 9-to-0 units wrap, at the 99-to-00 wrap, and on edges where hold falls while ticks keep arriving.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
    localparam int DIGIT_W   = 4;
    localparam int NUM_DIGS  = 2;
    localparam int RADIX     = 10;
    localparam int COUNT_W   = DIGIT_W * NUM_DIGS;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [COUNT_W-1:0] count_t;
endpackage

// File: rtl/rxn_decade.sv
module rxn_decade #(
    parameter int W     = 4,
    parameter int RADIX = 10
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] dig_o,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    // the set bits of the radix; a value below the radix never covers all of them
    localparam logic [W-1:0] WRAP_MASK = RADIX[W-1:0];

    typedef struct packed {
        logic [W-1:0] dig;
    } dec_st_t;

    dec_st_t      st_d, st_q;
    logic [W-1:0] step;
    logic         tenth;

    always_comb begin
        st_d   = st_q;
        step   = st_q.dig + 1'b1;
        tenth  = ((step & WRAP_MASK) == WRAP_MASK);
        wrap_o = inc_i & tenth & ~clr_i;
        if (clr_i) begin
            st_d.dig = '0;
        end else if (inc_i) begin
            st_d.dig = tenth ? '0 : step;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dig_o = st_q.dig;
    assign nxt_o = st_d.dig;
endmodule

// File: rtl/rxn_gate.sv
module rxn_gate (
    input  logic clk,
    input  logic clr_i,
    input  logic tick_i,
    input  logic start_i,
    input  logic stop_i,
    output logic run_o,
    output logic cnt_en_o
);
    typedef struct packed {
        logic run;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || stop_i) begin
            st_d.run = 1'b0;
        end else if (start_i) begin
            st_d.run = 1'b1;
        end
        cnt_en_o = st_q.run & tick_i & ~stop_i & ~clr_i;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/rxn_hold.sv
module rxn_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic         hold_i,
    input  logic [W-1:0] live_nxt_i,
    output logic [W-1:0] disp_o
);
    typedef struct packed {
        logic [W-1:0] disp;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.disp = '0;
        end else if (hold_i) begin
            st_d.disp = live_nxt_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign disp_o = st_q.disp;
endmodule

// File: rtl/rxn_timer.sv
module rxn_timer
    import rxn_pkg::*;
(
    input  logic               clk,
    input  logic               clr_i,
    input  logic               tick_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               hold_i,
    output logic [DIGIT_W-1:0] units_o,
    output logic [DIGIT_W-1:0] tens_o,
    output logic [DIGIT_W-1:0] disp_units_o,
    output logic [DIGIT_W-1:0] disp_tens_o,
    output logic               running_o,
    output logic               overflow_o
);
    typedef struct packed {
        logic ovf;
    } top_st_t;

    logic [NUM_DIGS-1:0] inc;
    logic [NUM_DIGS-1:0] wrap;
    count_t              live_q;
    count_t              live_d;
    count_t              disp;
    logic                cnt_en;
    top_st_t             st_d, st_q;

    rxn_gate u_gate (
        .clk      (clk),
        .clr_i    (clr_i),
        .tick_i   (tick_i),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .run_o    (running_o),
        .cnt_en_o (cnt_en)
    );

    for (genvar g = 0; g < NUM_DIGS; g++) begin : g_dec
        if (g == 0) begin : g_first
            assign inc[g] = cnt_en;
        end else begin : g_chain
            assign inc[g] = wrap[g-1];
        end

        rxn_decade #(
            .W     (DIGIT_W),
            .RADIX (RADIX)
        ) u_dec (
            .clk    (clk),
            .clr_i  (clr_i),
            .inc_i  (inc[g]),
            .dig_o  (live_q[g*DIGIT_W +: DIGIT_W]),
            .nxt_o  (live_d[g*DIGIT_W +: DIGIT_W]),
            .wrap_o (wrap[g])
        );
    end

    rxn_hold #(
        .W (COUNT_W)
    ) u_hold (
        .clk        (clk),
        .clr_i      (clr_i),
        .hold_i     (hold_i),
        .live_nxt_i (live_d),
        .disp_o     (disp)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.ovf = 1'b0;
        end else if (wrap[NUM_DIGS-1]) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign units_o      = live_q[0 +: DIGIT_W];
    assign tens_o       = live_q[DIGIT_W +: DIGIT_W];
    assign disp_units_o = disp[0 +: DIGIT_W];
    assign disp_tens_o  = disp[DIGIT_W +: DIGIT_W];
    assign overflow_o   = st_q.ovf;
endmodule

// File: rtl/rxn_timer_chk.sv
module rxn_timer_chk (
    input logic       clk,
    input logic       clr_i,
    input logic       tick_i,
    input logic       start_i,
    input logic       stop_i,
    input logic       hold_i,
    input logic [3:0] units_o,
    input logic [3:0] tens_o,
    input logic [3:0] disp_units_o,
    input logic [3:0] disp_tens_o,
    input logic       running_o,
    input logic       overflow_o
);
    bit armed_q;

    always_ff @(posedge clk) begin
        if (clr_i) armed_q <= 1'b1;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed_q)
        clr_i |=> (units_o == 4'd0 && tens_o == 4'd0 && disp_units_o == 4'd0 &&
                   disp_tens_o == 4'd0 && !running_o && !overflow_o)); // R1

    AST_UNITS_STEP: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && running_o && tick_i && !stop_i && units_o != 4'd9)
        |=> (units_o == $past(units_o) + 4'd1 && $stable(tens_o))); // R2

    AST_TENS_STEP: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && running_o && tick_i && !stop_i && units_o == 4'd9 && tens_o != 4'd9)
        |=> (units_o == 4'd0 && tens_o == $past(tens_o) + 4'd1)); // R3

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && running_o && tick_i && !stop_i && units_o == 4'd9 && tens_o == 4'd9)
        |=> (units_o == 4'd0 && tens_o == 4'd0 && overflow_o)); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && overflow_o) |=> overflow_o); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && !running_o) |=> ($stable(units_o) && $stable(tens_o))); // R5

    AST_START_OPEN: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && start_i && !stop_i) |=> running_o); // R6

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && stop_i) |=> (!running_o && $stable(units_o) && $stable(tens_o))); // R7

    AST_STOP_PRIO: assert property (@(posedge clk) disable iff (!armed_q)
        (start_i && stop_i) |=> !running_o); // R8

    AST_HOLD_FOLLOW: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && hold_i) |=> (disp_units_o == units_o && disp_tens_o == tens_o)); // R9

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!armed_q)
        (!clr_i && !hold_i) |=> ($stable(disp_units_o) && $stable(disp_tens_o))); // R9

    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_i |-> (units_o <= 4'd9 && tens_o <= 4'd9 &&
                    disp_units_o <= 4'd9 && disp_tens_o <= 4'd9)); // R10
endmodule

bind rxn_timer rxn_timer_chk u_chk (.*);

// File: tb/rxn_timer_tb.sv
`timescale 1ns/100ps
module rxn_timer_tb;
    logic       clk = 1'b0;
    logic       clr_i = 1'b0, tick_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, hold_i = 1'b1;
    logic [3:0] units_o, tens_o, disp_units_o, disp_tens_o;
    logic       running_o, overflow_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur = "R1";

    // behavioural reference
    int m_cnt = 0, m_disp = 0;
    bit m_run = 1'b0, m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    rxn_timer u_dut (
        .clk(clk), .clr_i(clr_i), .tick_i(tick_i), .start_i(start_i),
        .stop_i(stop_i), .hold_i(hold_i), .units_o(units_o), .tens_o(tens_o),
        .disp_units_o(disp_units_o), .disp_tens_o(disp_tens_o),
        .running_o(running_o), .overflow_o(overflow_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit tk, input bit st, input bit sp, input bit hd, input bit cl);
        tick_i = tk; start_i = st; stop_i = sp; hold_i = hd; clr_i = cl;
        @(posedge clk);
        if (cl) begin
            m_cnt = 0; m_run = 0; m_ovf = 0; m_disp = 0;
        end else begin
            if (m_run && tk && !sp) begin
                if (m_cnt == 99) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (sp) m_run = 0;
            else if (st) m_run = 1;
            if (hd) m_disp = m_cnt;
        end
        #1;
        chk(cur, "units", int'(units_o), m_cnt % 10);
        chk(cur, "tens", int'(tens_o), m_cnt / 10);
        chk(cur, "running", int'(running_o), int'(m_run));
        chk("R4", "overflow", int'(overflow_o), int'(m_ovf));
        chk("R9", "display", int'(disp_tens_o) * 10 + int'(disp_units_o), m_disp);
        chk("R10", "bcd range", int'(units_o <= 4'd9 && tens_o <= 4'd9 &&
                                    disp_units_o <= 4'd9 && disp_tens_o <= 4'd9), 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        #1;
        cur = "R1";
        step(0, 0, 0, 1, 1);
        step(1, 1, 0, 1, 1);

        cur = "R5";                      // ticks and stops with the gate closed
        for (int i = 0; i < 8; i++) step(1, 0, i[0], 1, 0);

        cur = "R6";                      // start together with a tick
        step(1, 1, 0, 1, 0);
        step(0, 0, 0, 1, 0);

        cur = "R2";                      // units 0..9 and wrap
        for (int i = 0; i < 12; i++) step(1, 0, 0, 1, 0);

        cur = "R3";                      // sparse ticks across tens steps
        for (int i = 0; i < 30; i++) step(i[0], 0, 0, 1, 0);

        cur = "R7";                      // stop with a tick, then repeated stops
        step(1, 0, 1, 1, 0);
        for (int i = 0; i < 6; i++) step(1, 0, i[1], 1, 0);

        cur = "R8";                      // start and stop together
        step(1, 1, 1, 1, 0);
        step(1, 0, 0, 1, 0);

        cur = "R9";                      // hold falls while counting continues
        step(0, 1, 0, 1, 0);
        for (int i = 0; i < 7; i++) step(1, 0, 0, 1, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0);

        cur = "R4";                      // run through 99 -> 00
        for (int i = 0; i < 110; i++) step(1, 0, 0, 1, 0);

        cur = "R1";                      // clear beats tick and start
        step(1, 1, 0, 1, 1);
        step(1, 0, 0, 0, 0);

        cur = "R10";
        step(0, 1, 0, 1, 0);
        for (int i = 0; i < 40; i++) step(1, 0, 0, i[2], 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule